// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector load or store command into a stream of memory addresses, one address per element. A command gives a logical start address, a signed stride that stays fixed for the whole access, and an element count. Each logical element address is relocated by a base register that system software writes through a separate port. The running program cannot read that register, so a job can be moved in memory without its addresses changing.

The stride may be any two's-complement value, so a matrix can be walked along a row, down a column or along a diagonal, forward or backward, with no need for the elements to be contiguous. A request longer than the vector register capacity is cut into segments of `SEG` elements (64 by default). Each address carries the index of its segment. A pulse marks the end of each segment and another marks the end of the job. The output has a valid/ready handshake; when the consumer is not ready, the generator holds its address.

Top module: `vec_addr_gen`

## Requirements
- R1: Every output address equals the base register plus the logical element address, modulo 2^AW. The base register has no read path; a write takes effect on the next clock edge.
- R2: The first address of a job is base plus the command's start. Element k has logical address start + k*stride.
- R3: The stride is a signed two's-complement value. Negative strides walk downward, and address arithmetic wraps modulo 2^AW without any flag.
- R4: Element k carries `out_seg` = floor(k / SEG). Every segment except the last holds exactly SEG elements. The last holds len mod SEG elements, or SEG if that remainder is zero.
- R5: `seg_done` is high for one cycle, in the cycle after the last address of each segment is accepted.
- R6: `job_done` is high for one cycle, in the cycle after the last address of a job is accepted. A zero-length command produces no address and raises `job_done` in the cycle after it is accepted.
- R7: `cmd_ready` is low from the cycle after a nonzero-length command is accepted until the cycle after the job's last address is accepted.
- R8: With `out_ready` held high, a job of length L is accepted and `job_done` rises L+1 cycles later, so one address is issued per clock.
- R9: While `out_valid` is high and `out_ready` is low, the address and segment tag hold their values and nothing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle and able to take a command |
| cmd_start | input | AW | Logical start address |
| cmd_stride | input | AW | Signed element increment |
| cmd_len | input | LW | Element count |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | AW | New base value |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | AW | Relocated element address |
| out_seg | output | LW-log2(SEG) | Segment index of the current element |
| seg_done | output | 1 | Pulse after the last address of a segment |
| job_done | output | 1 | Pulse after the last address of a job |

## Verification
The checks on stride stepping and stall holding assume that the base register is written only while no job is running, because a write during a job moves the output address by design. They also assume that a command and a base write never fall in the same cycle. The bench writes the base only between jobs and waits for `job_done` before changing it. It mixes runs with `out_ready` held high and runs with pseudo-random backpressure, so that the stall and timing rules are each tested under the conditions they apply to.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int SEG = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [AW-1:0]                 cmd_start,
  input  logic [AW-1:0]                 cmd_stride,
  input  logic [LW-1:0]                 cmd_len,
  input  logic                          base_we,
  input  logic [AW-1:0]                 base_wdata,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [AW-1:0]                 out_addr,
  output logic [LW-$clog2(SEG)-1:0]     out_seg,
  output logic                          seg_done,
  output logic                          job_done
);
  localparam int SW = $clog2(SEG);
  localparam int IW = LW - SW;

  logic [AW-1:0] base_q, addr_q, stride_q;
  logic [LW-1:0] rem_q;
  logic [SW-1:0] pos_q;
  logic [IW-1:0] seg_q;
  logic          busy_q, seg_done_q, job_done_q;

  logic cmd_fire, out_fire, last_elem, seg_end;

  assign cmd_ready = !busy_q;
  assign cmd_fire  = cmd_valid && !busy_q;
  assign out_fire  = busy_q && out_ready;
  assign last_elem = (rem_q == LW'(1));
  assign seg_end   = last_elem || (pos_q == SW'(SEG - 1));

  assign out_valid = busy_q;
  assign out_addr  = base_q + addr_q;
  assign out_seg   = seg_q;
  assign seg_done  = seg_done_q;
  assign job_done  = job_done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      addr_q     <= '0;
      stride_q   <= '0;
      rem_q      <= '0;
      pos_q      <= '0;
      seg_q      <= '0;
      busy_q     <= 1'b0;
      seg_done_q <= 1'b0;
      job_done_q <= 1'b0;
    end else begin
      seg_done_q <= out_fire && seg_end;
      job_done_q <= (out_fire && last_elem) || (cmd_fire && cmd_len == '0);
      if (base_we) base_q <= base_wdata;
      if (cmd_fire) begin
        addr_q   <= cmd_start;
        stride_q <= cmd_stride;
        rem_q    <= cmd_len;
        pos_q    <= '0;
        seg_q    <= '0;
        busy_q   <= (cmd_len != '0);
      end else if (out_fire) begin
        addr_q <= addr_q + stride_q;
        rem_q  <= rem_q - LW'(1);
        pos_q  <= pos_q + SW'(1);
        if (pos_q == SW'(SEG - 1)) seg_q <= seg_q + IW'(1);
        if (last_elem) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int SEG = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic [AW-1:0]             cmd_start,
  input logic [AW-1:0]             cmd_stride,
  input logic [LW-1:0]             cmd_len,
  input logic                      base_we,
  input logic [AW-1:0]             base_wdata,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [AW-1:0]             out_addr,
  input logic [LW-$clog2(SEG)-1:0] out_seg,
  input logic                      seg_done,
  input logic                      job_done
);
  localparam int SW = $clog2(SEG);
  localparam int IW = LW - SW;

  logic [AW-1:0] base_sh, stride_sh;
  logic [SW:0]   cnt;
  logic          fire, acc;

  assign fire = out_valid && out_ready;
  assign acc  = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_sh   <= '0;
      stride_sh <= '0;
      cnt       <= '0;
    end else begin
      if (base_we) base_sh <= base_wdata;
      if (acc) stride_sh <= cmd_stride;
      if (seg_done) cnt <= fire ? (SW+1)'(1) : '0;
      else if (fire) cnt <= cnt + (SW+1)'(1);
    end
  end

  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_len != '0) |=> (out_valid && out_addr == base_sh + $past(cmd_start)));

  a_r3_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!out_valid || out_addr == $past(out_addr) + stride_sh));

  a_r4_seg_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (SW+1)'(SEG));

  a_r4_seg_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_done && out_valid) |-> out_seg == $past(out_seg) + IW'(1));

  a_r5_seg_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> $past(fire));

  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_len == '0) |=> (job_done && !out_valid));

  a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_seg)));
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.AW(AW), .LW(LW), .SEG(SEG)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_start(cmd_start), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
  .base_we(base_we), .base_wdata(base_wdata), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_seg(out_seg),
  .seg_done(seg_done), .job_done(job_done)
);

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;
  localparam int AW = 32, LW = 16, SEG = 64;
  localparam int IW = LW - $clog2(SEG);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [IW-1:0] seg;
    logic          seg_last;
    logic          job_last;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [AW-1:0] cmd_start = '0, cmd_stride = '0, base_wdata = '0;
  logic [LW-1:0] cmd_len = '0;
  logic base_we = 0;
  logic out_valid, out_ready = 1, seg_done, job_done;
  logic [AW-1:0] out_addr;
  logic [IW-1:0] out_seg;

  int checks = 0, failures = 0;
  item_t q[$];
  logic [AW-1:0] base_model = '0;
  bit rnd_ready = 0, pending_zero = 0, prev_seg = 0, prev_job = 0, mon_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  vec_addr_gen #(.AW(AW), .LW(LW), .SEG(SEG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .base_we(base_we), .base_wdata(base_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_seg(out_seg),
    .seg_done(seg_done), .job_done(job_done));

  task automatic chk(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_ready ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      bit es, ej;
      es = prev_seg;
      ej = prev_job || pending_zero;
      pending_zero = 0;
      if (es || seg_done)
        chk(seg_done == es, "R5", $sformatf("seg_done act=%0b exp=%0b", seg_done, es));
      if (ej || job_done)
        chk(job_done == ej, "R6", $sformatf("job_done act=%0b exp=%0b", job_done, ej));
      prev_seg = 0;
      prev_job = 0;
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R2", "address issued with none expected");
        else begin
          item_t it;
          it = q.pop_front();
          chk(out_addr == it.addr, "R1",
              $sformatf("addr act=%h exp=%h", out_addr, it.addr));
          chk(out_seg == it.seg, "R4", $sformatf("seg act=%0d exp=%0d", out_seg, it.seg));
          prev_seg = it.seg_last;
          prev_job = it.job_last;
        end
      end
    end
  end

  task automatic set_base(logic [AW-1:0] v);
    @(posedge clk); #2;
    base_we = 1; base_wdata = v;
    @(posedge clk); #2;
    base_we = 0;
    base_model = v;
  endtask

  task automatic run_job(logic [AW-1:0] start, logic [AW-1:0] stride, int len, bit rnd);
    logic [AW-1:0] la;
    int n;
    la = start;
    for (int i = 0; i < len; i++) begin
      item_t it;
      it.addr = base_model + la;
      it.seg = IW'(i / SEG);
      it.seg_last = (i % SEG == SEG - 1) || (i == len - 1);
      it.job_last = (i == len - 1);
      q.push_back(it);
      la = la + stride;
    end
    rnd_ready = rnd;
    @(posedge clk); #2;
    cmd_valid = 1; cmd_start = start; cmd_stride = stride; cmd_len = LW'(len);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_valid = 0;
    if (len == 0) pending_zero = 1;
    else chk(cmd_ready == 0, "R7", $sformatf("cmd_ready act=%0b exp=0", cmd_ready));
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (len != 0 && !job_done)
        if (cmd_ready) chk(0, "R7", "cmd_ready act=1 exp=0 during job");
    end while (!job_done);
    if (!rnd)
      chk(n == len + 1, "R8", $sformatf("cycles to job_done act=%0d exp=%0d", n, len + 1));
    #1;
    chk(q.size() == 0, "R6", $sformatf("pending items act=%0d exp=0", q.size()));
    chk(cmd_ready == 1, "R7", $sformatf("cmd_ready after job act=%0b exp=1", cmd_ready));
    rnd_ready = 0;
  endtask

  task automatic stall_probe();
    logic [AW-1:0] a0;
    logic [IW-1:0] s0;
    rnd_ready = 0;
    set_base(32'h0000_4000);
    @(posedge clk); #2;
    cmd_valid = 1; cmd_start = 32'h80; cmd_stride = 32'h4; cmd_len = 16'd3;
    force out_ready = 1'b0;
    @(posedge clk); #2;
    cmd_valid = 0;
    a0 = out_addr; s0 = out_seg;
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid && out_addr == a0 && out_seg == s0, "R9",
        $sformatf("stalled addr act=%h exp=%h", out_addr, a0));
    chk(a0 == 32'h4080, "R2", $sformatf("first addr act=%h exp=%h", a0, 32'h4080));
    release out_ready;
    out_ready = 1;
    q.push_back('{32'h4080, '0, 1'b0, 1'b0});
    q.push_back('{32'h4084, '0, 1'b0, 1'b0});
    q.push_back('{32'h4088, '0, 1'b1, 1'b1});
    mon_on = 1;
    while (!job_done) @(negedge clk);
    #1;
    chk(q.size() == 0, "R9", $sformatf("pending after stall act=%0d exp=0", q.size()));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && cmd_ready && !seg_done && !job_done, "R7",
        $sformatf("reset state valid=%0b ready=%0b", out_valid, cmd_ready));
    mon_on = 1;
    set_base(32'h0000_1000);
    run_job(32'h10, 32'd4, 5, 0);
    set_base(32'h2000_0000);
    run_job(32'h100, -32'sd8, 70, 0);
    set_base(32'h20);
    run_job(32'hFFFF_FFF0, 32'h10, 3, 0);
    set_base(32'h0);
    run_job(32'h500, 32'd3, 128, 1);
    run_job(32'h42, 32'd7, 0, 0);
    set_base(32'h7777_0000);
    run_job(32'h0, 32'h41, 64, 1);
    run_job(32'hABC, 32'd1, 1, 0);
    run_job(32'h9000, -32'sd1, 130, 1);
    mon_on = 0;
    @(negedge clk);
    stall_probe();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule